// File: doc/BRIEF.md
# Automatic Status Polling Matcher

This block keeps a serial flash under watch without software involvement. Once started in its polling mode, it issues a complete read command frame, collects the returned status bytes and compares them with a programmed mask and expected value. It then waits a programmed number of clock cycles with chip select released and issues the next frame. The block can be set to halt on the first successful comparison, or to keep polling indefinitely.

A successful comparison sets a sticky match flag. The flag also drives an interrupt line when the interrupt enable is set. The most recent status value is held on an output for readback. An abort request ends any activity at once. The command frame uses the same layout as the rest of the flash sequencer: an instruction phase, an optional address phase, dummy cycles and a data phase. Each phase carries its own width code.

Top module: `status_poll_top`

## Requirements
- R1: Polling starts only when `start` is pulsed while `fmode` equals 2 and the block is idle. A start pulse with any other `fmode` code leaves `busy` low and `cs_n` high.
- R2: A frame is sent with `cs_n` low. Its phases come in this order: instruction (8 bits), address (`asize`+1 bytes), `dcyc` dummy cycles, and data. For each phase, a width code of 0 skips the phase. Code 1 uses one line: out on `io_out[0]`, in on `io_in[1]`. Code 2 uses two lines, `io[1:0]`. Code 3 uses four lines, `io[3:0]`. A data-width code of 0 is treated as one line. Bits are sent MSB first. Each bus cycle lasts two clocks, `sck` low and then high, and the input is sampled at the end of the high clock.
- R3: Each frame reads `dlen`+1 status bytes. The value is formed with the first received byte most significant, zero-extended to 32 bits, and is placed on `status_q` when the frame ends.
- R4: A frame hits when (status AND `mask`) equals (`match_val` AND `mask`). A hit sets `match_flag`, which then stays set.
- R5: With `stop_on_match` set, a hit ends polling: `busy` falls and `cs_n` stays high.
- R6: With `stop_on_match` clear, polling carries on after a hit.
- R7: Between two frames of one polling run, `cs_n` is high for exactly `interval`+2 clock cycles.
- R8: `match_clr` clears `match_flag` on the next edge. If a hit falls in the same cycle, the set wins.
- R9: `irq` is high exactly when `match_flag` and `match_ie` are both set.
- R10: After the edge that samples `abort_req`, `cs_n` is high and `busy` is low, even in the middle of a frame. `abort_pending` is high for that one cycle and then clears itself once the bus is idle.
- R11: `busy` is high from an accepted start until a stop on match or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| fmode | input | 2 | Function mode; 2 selects polling |
| abort_req | input | 1 | One-cycle request to end all activity |
| instr | input | 8 | Instruction byte |
| imode | input | 2 | Instruction width code |
| amode | input | 2 | Address width code |
| asize | input | 2 | Address bytes minus one |
| addr | input | 32 | Address value |
| dcyc | input | 5 | Dummy cycle count |
| dmode | input | 2 | Data width code |
| dlen | input | 2 | Status bytes per frame minus one |
| mask | input | 32 | Compare mask |
| match_val | input | 32 | Expected status value |
| interval | input | 16 | Idle clocks between frames, minus two |
| stop_on_match | input | 1 | Halt polling on the first hit |
| match_ie | input | 1 | Match interrupt enable |
| match_clr | input | 1 | Write-one-to-clear of the match flag |
| io_in | input | 4 | Data lines from the flash |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data lines to the flash |
| io_oe | output | 4 | Output enables of the data lines |
| busy | output | 1 | Polling run active |
| abort_pending | output | 1 | Abort in progress |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt |
| status_q | output | 32 | Last received status value |

## Verification
Two functions can fall in the same cycle: a software clear of the match flag and a new hit from the frame that has just ended. The bench runs continuous polling with a status that always hits. It watches for `cs_n` rising, then asserts `match_clr` in the very next cycle, which is the cycle in which the frame result is judged. It expects the flag to stay set. A second clear, issued during the long idle gap that follows, must drop the flag. This shows that the clear works on its own, and that it loses only when it collides with a hit.

// File: rtl/status_poll_pkg.sv
// Shared types and constants of the status polling matcher.
package status_poll_pkg;
    localparam int FLASH_ADDR_W = 32;          // address phase shift width
    localparam int STAT_BYTES   = 4;           // max status bytes per frame
    localparam int STAT_W       = 8 * STAT_BYTES;
    localparam int DCYC_W       = 5;
    localparam int CNT_W        = $clog2(FLASH_ADDR_W) + 1;
    localparam logic [1:0] FMODE_POLL = 2'd2;

    typedef enum logic [2:0] {PH_IDLE, PH_INSTR, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;
    typedef enum logic [1:0] {T_IDLE, T_RUN, T_WAIT} poll_st_e;

    typedef struct packed {
        logic [7:0]              instr;
        logic [1:0]              imode;
        logic [1:0]              amode;
        logic [1:0]              asize;
        logic [FLASH_ADDR_W-1:0] addr;
        logic [DCYC_W-1:0]       dcyc;
        logic [1:0]              dmode;
        logic [1:0]              dlen;
    } frame_cfg_t;
endpackage

// File: rtl/poll_frame_phy.sv
// Runs one command frame on the serial flash bus when `go` is pulsed.
// Assumes: cfg is stable during a frame; `kill` resets the bus at once.
// Every bus cycle lasts two clocks (sck low, then high). Input is taken at the
// end of the high clock. `done` pulses one cycle after the last bit.
module poll_frame_phy
    import status_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              go,
    input  frame_cfg_t        cfg,
    input  logic [3:0]        io_in,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              done,
    output logic [STAT_W-1:0] rx
);
    localparam int SH_W = FLASH_ADDR_W;

    phase_e            ph, nph;
    logic [SH_W-1:0]   sh, nsh;
    logic [CNT_W-1:0]  cnt, ncnt;
    logic [1:0]        lg, nlg;
    logic              half;

    // log2 of the lines used by a width code (code 0 maps to one line)
    function automatic logic [1:0] lanes_log(input logic [1:0] m);
        case (m)
            2'd2:    lanes_log = 2'd1;
            2'd3:    lanes_log = 2'd2;
            default: lanes_log = 2'd0;
        endcase
    endfunction

    // first enabled phase after p; data always runs, IDLE ends the frame
    function automatic phase_e phase_after(input phase_e p, input frame_cfg_t c);
        phase_e n;
        n = PH_IDLE;
        if (p == PH_IDLE && c.imode != 2'd0)
            n = PH_INSTR;
        else if ((p == PH_IDLE || p == PH_INSTR) && c.amode != 2'd0)
            n = PH_ADDR;
        else if (p != PH_DUMMY && p != PH_DATA && c.dcyc != '0)
            n = PH_DUMMY;
        else if (p != PH_DATA)
            n = PH_DATA;
        return n;
    endfunction

    // loading values for the phase that follows the current one
    always_comb begin
        nph  = phase_after(ph, cfg);
        ncnt = '0;
        nsh  = '0;
        nlg  = 2'd0;
        case (nph)
            PH_INSTR: begin
                nlg  = lanes_log(cfg.imode);
                nsh  = {cfg.instr, {(SH_W-8){1'b0}}};
                ncnt = CNT_W'(6'd8 >> nlg);
            end
            PH_ADDR: begin
                nlg  = lanes_log(cfg.amode);
                nsh  = cfg.addr << {2'(2'd3 - cfg.asize), 3'b000};
                ncnt = CNT_W'(({4'd0, cfg.asize} + 6'd1) * 6'd8 >> nlg);
            end
            PH_DUMMY: ncnt = CNT_W'(cfg.dcyc);
            PH_DATA: begin
                nlg  = lanes_log(cfg.dmode);
                ncnt = CNT_W'(({4'd0, cfg.dlen} + 6'd1) * 6'd8 >> nlg);
            end
            default: ncnt = '0;
        endcase
    end

    // phase sequencing, shifting out and sampling in
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            ph   <= PH_IDLE;
            half <= 1'b0;
            cnt  <= '0;
            sh   <= '0;
            lg   <= 2'd0;
            rx   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ph == PH_IDLE) begin
                if (go) begin
                    ph   <= nph;
                    cnt  <= ncnt;
                    sh   <= nsh;
                    lg   <= nlg;
                    half <= 1'b0;
                    rx   <= '0;
                end
            end else if (!half) begin
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                if (ph == PH_DATA) begin
                    case (lg)
                        2'd1:    rx <= {rx[STAT_W-3:0], io_in[1:0]};
                        2'd2:    rx <= {rx[STAT_W-5:0], io_in};
                        default: rx <= {rx[STAT_W-2:0], io_in[1]};
                    endcase
                end
                sh <= sh << (3'd1 << lg);
                if (cnt == CNT_W'(1)) begin
                    ph   <= nph;
                    cnt  <= ncnt;
                    sh   <= nsh;
                    lg   <= nlg;
                    done <= (nph == PH_IDLE);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // pin drive: only instruction and address phases own the lines
    always_comb begin
        cs_n   = (ph == PH_IDLE);
        sck    = half;
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        if (ph == PH_INSTR || ph == PH_ADDR) begin
            case (lg)
                2'd1:    begin io_out = {2'b00, sh[SH_W-1 -: 2]}; io_oe = 4'b0011; end
                2'd2:    begin io_out = sh[SH_W-1 -: 4];          io_oe = 4'b1111; end
                default: begin io_out = {3'b000, sh[SH_W-1]};     io_oe = 4'b0001; end
            endcase
        end
    end

    // R2: the frame-end pulse comes only with the bus released
    a_r2_done_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !sck));
    // R2: lines are never driven while the flash answers
    a_r2_no_drive_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DATA || ph == PH_DUMMY) |-> (io_oe == 4'b0000));
endmodule

// File: rtl/poll_match.sv
// Masked comparison of a received status value with the expected one.
// Assumes: the inputs are stable while `hit` is used.
module poll_match
    import status_poll_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    input  logic [STAT_W-1:0] expect_val,
    output logic              hit
);
    // hit when every masked bit agrees
    always_comb hit = ((status ^ expect_val) & mask) == '0;
endmodule

// File: rtl/status_poll_top.sv
// Automatic status polling: issues a status-read frame, compares the result,
// waits `interval`+2 idle clocks, and repeats until a stop on match or an abort.
// Assumes: configuration inputs are held steady during a polling run.
module status_poll_top
    import status_poll_pkg::*;
#(
    parameter int IVL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              fmode,
    input  logic                    abort_req,
    input  logic [7:0]              instr,
    input  logic [1:0]              imode,
    input  logic [1:0]              amode,
    input  logic [1:0]              asize,
    input  logic [FLASH_ADDR_W-1:0] addr,
    input  logic [DCYC_W-1:0]       dcyc,
    input  logic [1:0]              dmode,
    input  logic [1:0]              dlen,
    input  logic [STAT_W-1:0]       mask,
    input  logic [STAT_W-1:0]       match_val,
    input  logic [IVL_W-1:0]        interval,
    input  logic                    stop_on_match,
    input  logic                    match_ie,
    input  logic                    match_clr,
    input  logic [3:0]              io_in,
    output logic                    sck,
    output logic                    cs_n,
    output logic [3:0]              io_out,
    output logic [3:0]              io_oe,
    output logic                    busy,
    output logic                    abort_pending,
    output logic                    match_flag,
    output logic                    irq,
    output logic [STAT_W-1:0]       status_q
);
    poll_st_e          st;
    logic [IVL_W-1:0]  wcnt;
    logic              accept, go, hit, phy_done;
    logic [STAT_W-1:0] phy_rx;
    frame_cfg_t        cfg;

    // gather the frame fields for the bus engine
    always_comb begin
        cfg.instr = instr;
        cfg.imode = imode;
        cfg.amode = amode;
        cfg.asize = asize;
        cfg.addr  = addr;
        cfg.dcyc  = dcyc;
        cfg.dmode = dmode;
        cfg.dlen  = dlen;
    end

    // launch a frame on an accepted start or at the end of the gap
    always_comb begin
        accept = start && fmode == FMODE_POLL && st == T_IDLE && !abort_req;
        go     = accept || (st == T_WAIT && wcnt == '0 && !abort_req);
    end

    poll_frame_phy i_phy (
        .clk    (clk),
        .rst_n  (rst_n),
        .kill   (abort_req),
        .go     (go),
        .cfg    (cfg),
        .io_in  (io_in),
        .sck    (sck),
        .cs_n   (cs_n),
        .io_out (io_out),
        .io_oe  (io_oe),
        .done   (phy_done),
        .rx     (phy_rx)
    );

    poll_match i_match (
        .status     (phy_rx),
        .mask       (mask),
        .expect_val (match_val),
        .hit        (hit)
    );

    // polling sequence, gap timer, sticky flag and abort handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= T_IDLE;
            wcnt          <= '0;
            match_flag    <= 1'b0;
            status_q      <= '0;
            abort_pending <= 1'b0;
        end else begin
            if (match_clr)
                match_flag <= 1'b0;
            if (abort_req) begin
                st            <= T_IDLE;
                abort_pending <= 1'b1;
            end else begin
                if (abort_pending && st == T_IDLE && cs_n)
                    abort_pending <= 1'b0;
                case (st)
                    T_IDLE: if (accept) st <= T_RUN;
                    T_RUN: if (phy_done) begin
                        status_q <= phy_rx;
                        if (hit)
                            match_flag <= 1'b1;
                        if (hit && stop_on_match) begin
                            st <= T_IDLE;
                        end else begin
                            st   <= T_WAIT;
                            wcnt <= interval;
                        end
                    end
                    T_WAIT: begin
                        if (wcnt == '0) st <= T_RUN;
                        else            wcnt <= wcnt - 1'b1;
                    end
                    default: st <= T_IDLE;
                endcase
            end
        end
    end

    // outputs derived from state
    always_comb begin
        busy = (st != T_IDLE);
        irq  = match_flag && match_ie;
    end

    a_r5_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_RUN && phy_done && hit && stop_on_match && !abort_req) |=> (!busy && cs_n));
    a_r6_keep_polling: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_RUN && phy_done && !stop_on_match && !abort_req) |=> busy);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !match_clr) |=> match_flag);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_RUN && phy_done && hit && !abort_req) |=> match_flag);
    a_r10_abort_now: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (!busy && cs_n && abort_pending));
    a_r7_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == T_WAIT) |-> cs_n);
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag && match_ie));
endmodule

// File: tb/test_status_poll_top.sv
`timescale 1ns/1ps
module test_status_poll_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort_req = 1'b0, match_clr = 1'b0;
    logic [1:0]  fmode = 2'd0;
    logic [7:0]  instr = 8'h00;
    logic [1:0]  imode = 2'd1, amode = 2'd0, asize = 2'd0, dmode = 2'd1, dlen = 2'd0;
    logic [31:0] addr = 32'h0, mask = 32'h0, match_val = 32'h0;
    logic [4:0]  dcyc = 5'd0;
    logic [15:0] interval = 16'd0;
    logic        stop_on_match = 1'b0, match_ie = 1'b0;
    logic [3:0]  io_in = 4'h0;
    logic        sck, cs_n, busy, abort_pending, match_flag, irq;
    logic [3:0]  io_out, io_oe;
    logic [31:0] status_q;

    int n_chk = 0, n_bad = 0;
    int fcnt = 0, sckcnt = 0;
    logic [31:0] vals [0:7];
    logic [31:0] cap_i = 0, cap_a = 0, last_i = 0, last_a = 0;

    always #10 clk = ~clk;

    status_poll_top i_status_poll_top (
        .clk(clk), .rst_n(rst_n), .start(start), .fmode(fmode), .abort_req(abort_req),
        .instr(instr), .imode(imode), .amode(amode), .asize(asize), .addr(addr),
        .dcyc(dcyc), .dmode(dmode), .dlen(dlen), .mask(mask), .match_val(match_val),
        .interval(interval), .stop_on_match(stop_on_match), .match_ie(match_ie),
        .match_clr(match_clr), .io_in(io_in), .sck(sck), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .busy(busy), .abort_pending(abort_pending),
        .match_flag(match_flag), .irq(irq), .status_q(status_q)
    );

    function automatic int lanes(input logic [1:0] m);
        return (m == 2'd3) ? 4 : (m == 2'd2) ? 2 : 1;
    endfunction

    // flash model: records command bits, returns the current frame's status
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            fcnt   = fcnt + 1;
            sckcnt = 0;
            last_i = cap_i;
            last_a = cap_a;
            cap_i  = 0;
            cap_a  = 0;
        end else begin
            int c, ic, ac, pre, w, nb, j;
            logic [31:0] s;
            c   = sckcnt;
            sckcnt = sckcnt + 1;
            ic  = (imode == 0) ? 0 : 8 / lanes(imode);
            ac  = (amode == 0) ? 0 : (int'(asize) + 1) * 8 / lanes(amode);
            pre = ic + ac + int'(dcyc);
            w   = lanes(dmode);
            nb  = (int'(dlen) + 1) * 8;
            s   = vals[(fcnt > 7) ? 7 : fcnt];
            if (c < ic)
                cap_i = (cap_i << lanes(imode)) | (32'(io_out) & ((32'd1 << lanes(imode)) - 1));
            else if (c < ic + ac)
                cap_a = (cap_a << lanes(amode)) | (32'(io_out) & ((32'd1 << lanes(amode)) - 1));
            if (c >= pre && c < pre + nb / w) begin
                j = c - pre;
                s = (s >> (nb - (j + 1) * w)) & ((32'd1 << w) - 1);
                io_in = (w == 1) ? {2'b00, s[0], 1'b0} : s[3:0];
            end else begin
                io_in = 4'h0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [1:0] fm);
        fmode = fm; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_rise();
        logic prev;
        prev = cs_n;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!prev && cs_n) break;
            prev = cs_n;
        end
    endtask

    task automatic do_abort();
        for (int i = 0; i < 20000 && cs_n; i++) @(negedge clk);
        tick(3);
        abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        chk("R10 cs_n released at once", cs_n, 1);
        chk("R10 busy low after abort", busy, 0);
        chk("R10 abort pending", abort_pending, 1);
        @(negedge clk);
        chk("R10 abort bit self-clears", abort_pending, 0);
    endtask

    // R1: only function mode 2 starts polling
    task automatic t_mode_gate();
        pulse_start(2'd1);
        tick(4);
        chk("R1 busy after wrong mode", busy, 0);
        chk("R1 cs_n after wrong mode", cs_n, 1);
    endtask

    // single-line frame, stop on third frame, gap 7
    task automatic t_single_stop();
        int base, gap;
        instr = 8'h05; imode = 2'd1; amode = 2'd0; dcyc = 5'd0; dmode = 2'd1; dlen = 2'd0;
        mask = 32'h01; match_val = 32'h00; interval = 16'd5; stop_on_match = 1'b1; match_ie = 1'b1;
        vals[0] = 32'h03; vals[1] = 32'h03; vals[2] = 32'h02;
        for (int k = 3; k < 8; k++) vals[k] = 32'h02;
        fcnt = 0; base = 0;
        pulse_start(2'd2);
        chk("R11 busy after start", busy, 1);
        chk("R2 cs_n low in frame", cs_n, 0);
        wait_rise();
        gap = 0;
        while (cs_n && gap < 1000) begin gap++; @(negedge clk); end
        chk("R7 gap equals interval+2", gap, 7);
        wait_idle();
        chk("R5 polling stopped", busy, 0);
        chk("R5 frames before stop", fcnt - base, 3);
        chk("R3 status zero-extended", status_q, 32'h02);
        chk("R4 flag set on hit", match_flag, 1);
        chk("R9 irq with enable", irq, 1);
        chk("R2 single-line instruction", last_i, 32'h05);
        match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
        chk("R8 clear drops flag", match_flag, 0);
    endtask

    // wide frame: quad instruction, dual 3-byte address, dummies, quad 2-byte data
    task automatic t_wide_frame();
        instr = 8'h9F; imode = 2'd3; amode = 2'd2; asize = 2'd2; addr = 32'h00AB_CDEF;
        dcyc = 5'd4; dmode = 2'd3; dlen = 2'd1; interval = 16'd0;
        mask = 32'hFF00; match_val = 32'hA500; stop_on_match = 1'b1;
        vals[0] = 32'h1234;
        for (int k = 1; k < 8; k++) vals[k] = 32'hA5F0;
        fcnt = 0;
        pulse_start(2'd2);
        wait_idle();
        chk("R4 hit on second frame", fcnt, 2);
        chk("R3 two-byte status order", status_q, 32'hA5F0);
        chk("R2 quad instruction", last_i, 32'h9F);
        chk("R2 dual 3-byte address", last_a, 32'h00AB_CDEF);
    endtask

    // R6 continuous polling, then abort mid-frame
    task automatic t_continue_abort();
        imode = 2'd1; amode = 2'd0; dcyc = 5'd0; dmode = 2'd2; dlen = 2'd0;
        mask = 32'h80; match_val = 32'h80; interval = 16'd3; stop_on_match = 1'b0; match_ie = 1'b1;
        for (int k = 0; k < 8; k++) vals[k] = 32'hC1;
        fcnt = 0;
        pulse_start(2'd2);
        for (int i = 0; i < 20000 && fcnt < 3; i++) @(negedge clk);
        chk("R6 still polling after hit", busy, 1);
        chk("R4 flag after hit", match_flag, 1);
        chk("R3 dual-line status", status_q, 32'hC1);
        do_abort();
        match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
        chk("R9 irq follows clear", irq, 0);
    endtask

    // R8 clear colliding with a hit; clear alone in the gap
    task automatic t_clear_collide();
        int gap;
        dmode = 2'd1; mask = 32'h0F; match_val = 32'h0A; interval = 16'd40;
        stop_on_match = 1'b0; match_ie = 1'b0;
        for (int k = 0; k < 8; k++) vals[k] = 32'h5A;
        fcnt = 0;
        pulse_start(2'd2);
        wait_rise();
        match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
        chk("R8 hit wins over clear", match_flag, 1);
        chk("R9 irq masked", irq, 0);
        tick(3);
        match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
        chk("R8 clear in quiet gap", match_flag, 0);
        wait_rise();
        gap = 0;
        while (cs_n && gap < 1000) begin gap++; @(negedge clk); end
        chk("R7 gap with interval 40", gap, 42);
        do_abort();
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) vals[k] = 32'h0;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", busy, 0);
        chk("R4 reset flag", match_flag, 0);
        chk("R2 reset cs_n", cs_n, 1);
        chk("R3 reset status", status_q, 0);
        t_mode_gate();
        t_single_stop();
        t_wide_frame();
        t_continue_abort();
        t_clear_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule